// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic datapath of a small accumulator machine. Each cycle it takes an operation code, two 8-bit operands (A is the accumulator side, B the second source) and the incoming carry flag. One clock edge later it presents the 8-bit result, a flag byte, a four-bit mask naming the flags the operation updates, and a strobe saying whether the result should be written back.

The surrounding core keeps the flag register itself. It merges the new flag byte into that register under the mask. Operations that leave a flag alone therefore say so through the mask, and the block never needs the old flag value, apart from carry-in. Stack-pointer offset arithmetic uses the same adder: the pointer's low byte goes on A and the signed offset byte on B, and the block returns the low result byte and the two carry flags that the core needs.

All sixteen operation codes are defined. Two are add-type, two are subtract-type, plus compare, increment, decrement, three bitwise operations, complement, four single-bit rotates and the pointer-offset flag operation.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte carries zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4, and its bits 3..0 always read 0. The update mask uses bits 3,2,1,0 for zero, subtract, half-carry and carry. A flag the operation does not update reads 0 in the flag byte.
- R2: Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 increment A, 6 decrement A, 7 AND, 8 OR, 9 XOR, 10 complement A, 11 rotate A left circular, 12 rotate A right circular, 13 rotate A left through carry, 14 rotate A right through carry, 15 pointer offset.
- R3: Add (carry-in 0) and add-with-carry (carry-in = cy_i) return A+B+cin modulo 256. Zero is set when that result is 0. Subtract is cleared. Half-carry is set when the low-nibble sum plus cin exceeds 15. Carry is set when the full sum exceeds 255. All four flags are updated.
- R4: Subtract (borrow-in 0) and subtract-with-borrow (borrow-in = cy_i) return A-B-bin modulo 256. Subtract is set. Half-carry is set when the low nibble of A is less than the low nibble of B plus bin. Carry is set when A is less than B+bin. Zero is set when the result is 0. All four flags are updated.
- R5: Compare produces exactly the flags and mask of subtract. The result strobe is low and the result port shows A.
- R6: Increment and decrement return A+1 and A-1 modulo 256 and never update carry (mask 1110). Increment clears subtract and sets half-carry when A's low nibble is 0xF. Decrement sets subtract and sets half-carry when A's low nibble is 0x0. Both set zero from the result.
- R7: AND sets half-carry and clears subtract and carry. OR and XOR clear subtract, half-carry and carry. All three set zero from the result and update all four flags.
- R8: The four rotates move A by one bit. Circular rotates feed the bit shifted out back into the vacated bit. Rotates through carry feed cy_i into the vacated bit. All four load carry with the bit shifted out, force zero, subtract and half-carry to 0, and update all four flags.
- R9: Complement returns ~A, sets subtract and half-carry, and updates only those two (mask 0110).
- R10: Pointer offset returns (A+B) modulo 256 and clears zero and subtract. Half-carry is set when that result's low nibble is below A's low nibble. Carry is set when the result is below A. All four flags are updated.
- R11: Outputs are registered. Inputs present before a rising edge appear on the outputs after that edge and hold until the next one. A synchronous active-high reset drives every output to 0.
- R12: Every operation except compare raises the result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (R2) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 8 | Registered result |
| flag_byte_o | output | 8 | Registered flag byte (R1 layout) |
| flag_we_o | output | 4 | Flags updated by the operation |
| res_we_o | output | 1 | Result write-back strobe |

## Verification
The bound properties compare outputs against the inputs of the previous cycle. They therefore assume that every input is a known value at each rising edge once reset is low, and that a one-cycle registered path is the contract. The bench drives every input on the falling edge, and never leaves one undriven after reset. Every 4-bit code is meaningful, so no stimulus can stray outside the legal operation set. Exhaustive operand sweeps and directed nibble and byte boundaries cover the carry and borrow rules.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CP   = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_CPL  = 4'd10,
    OP_RLC  = 4'd11,
    OP_RRC  = 4'd12,
    OP_RL   = 4'd13,
    OP_RR   = 4'd14,
    OP_SPOF = 4'd15
  } alu_op_e;

  // mask bit positions; the flag byte places each at index + 4
  localparam int FL_Z = 3;
  localparam int FL_N = 2;
  localparam int FL_H = 1;
  localparam int FL_C = 0;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              half_o,
  output logic              carry_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0] full;
  logic [NIB_W:0]  nib;

  // the extra top bit is the carry on add and the wrap (borrow) on subtract
  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    end
  end

  assign sum_o   = full[DATA_W-1:0];
  assign carry_o = full[DATA_W];
  assign half_o  = nib[NIB_W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_rot.sv
module alu8_rot #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              left_i,
  input  logic              thru_i,
  output logic [DATA_W-1:0] y_o,
  output logic              out_o
);
  logic fill;

  always_comb begin
    if (left_i) begin
      out_o = a_i[DATA_W-1];
      fill  = thru_i ? cy_i : a_i[DATA_W-1];
      y_o   = {a_i[DATA_W-2:0], fill};
    end else begin
      out_o = a_i[0];
      fill  = thru_i ? cy_i : a_i[0];
      y_o   = {fill, a_i[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flag_byte_o,
  output logic [FLAG_N-1:0] flag_we_o,
  output logic              res_we_o
);
  localparam int FB_W = 2 * FLAG_N;
  localparam logic [FLAG_N-1:0] WE_ALL = '1;
  localparam logic [FLAG_N-1:0] WE_NOC = WE_ALL & ~(FLAG_N'(1) << FL_C);
  localparam logic [FLAG_N-1:0] WE_NH  = (FLAG_N'(1) << FL_N) | (FLAG_N'(1) << FL_H);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // shared adder/subtractor operand steering
  logic [DATA_W-1:0] as_b, as_sum;
  logic              as_cin, as_sub, as_half, as_carry;

  always_comb begin
    as_b   = b_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_cin = cy_i;
      OP_SUB, OP_CP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = cy_i; end
      OP_INC: begin as_b = '0; as_cin = 1'b1; end
      OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .half_o(as_half), .carry_o(as_carry)
  );

  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] lg_y;

  always_comb begin
    case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_NOT;
    endcase
  end

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .y_o(lg_y)
  );

  logic [DATA_W-1:0] rt_y;
  logic              rt_out, rt_left, rt_thru;

  assign rt_left = (op == OP_RLC) || (op == OP_RL);
  assign rt_thru = (op == OP_RL)  || (op == OP_RR);

  alu8_rot #(.DATA_W(DATA_W)) u_rot (
    .a_i(a_i), .cy_i(cy_i), .left_i(rt_left), .thru_i(rt_thru),
    .y_o(rt_y), .out_o(rt_out)
  );

  // result, flag and mask selection
  logic [DATA_W-1:0] nx_res;
  logic [FLAG_N-1:0] nx_fl, nx_we;
  logic              nx_rwe;

  always_comb begin
    nx_res = a_i;
    nx_fl  = '0;
    nx_we  = '0;
    nx_rwe = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
        nx_res       = (op == OP_CP) ? a_i : as_sum;
        nx_rwe       = (op != OP_CP);
        nx_fl[FL_Z]  = (as_sum == '0);
        nx_fl[FL_N]  = as_sub;
        nx_fl[FL_H]  = as_half;
        nx_fl[FL_C]  = as_carry;
        nx_we        = WE_ALL;
      end
      OP_INC, OP_DEC: begin
        nx_res       = as_sum;
        nx_fl[FL_Z]  = (as_sum == '0);
        nx_fl[FL_N]  = as_sub;
        nx_fl[FL_H]  = as_half;
        nx_we        = WE_NOC;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nx_res       = lg_y;
        nx_fl[FL_Z]  = (lg_y == '0);
        nx_fl[FL_H]  = (op == OP_AND);
        nx_we        = WE_ALL;
      end
      OP_CPL: begin
        nx_res       = lg_y;
        nx_fl[FL_N]  = 1'b1;
        nx_fl[FL_H]  = 1'b1;
        nx_we        = WE_NH;
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR: begin
        nx_res       = rt_y;
        nx_fl[FL_C]  = rt_out;
        nx_we        = WE_ALL;
      end
      OP_SPOF: begin
        nx_res       = as_sum;
        nx_fl[FL_H]  = as_half;
        nx_fl[FL_C]  = as_carry;
        nx_we        = WE_ALL;
      end
      default: begin
        nx_rwe = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      flag_byte_o <= '0;
      flag_we_o   <= '0;
      res_we_o    <= 1'b0;
    end else begin
      res_o       <= nx_res;
      flag_byte_o <= {nx_fl, {(FB_W-FLAG_N){1'b0}}};
      flag_we_o   <= nx_we;
      res_we_o    <= nx_rwe;
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_N = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cy_i,
  input logic [DATA_W-1:0] res_o,
  input logic [7:0]        flag_byte_o,
  input logic [FLAG_N-1:0] flag_we_o,
  input logic              res_we_o
);
  AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=> !flag_we_o[FL_C]); // R6

  AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CP) |=> (!res_we_o && res_o == $past(a_i))); // R5

  AST_AND_HALF: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND) |=> (flag_byte_o[5] && !flag_byte_o[6] && !flag_byte_o[4])); // R7

  AST_ROT_ZNH_LOW: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RLC || op_i == OP_RRC || op_i == OP_RL || op_i == OP_RR)
    |=> (flag_byte_o[7:5] == 3'b000)); // R8

  AST_RL_THRU_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RL) |=> (res_o[0] == $past(cy_i) && flag_byte_o[4] == $past(a_i[DATA_W-1]))); // R8

  AST_CPL_MASK: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CPL) |=> (res_o == ~$past(a_i) && flag_we_o == 4'b0110)); // R9

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (res_o == DATA_W'($past(a_i) + $past(b_i)))); // R3

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SPOF) |=> (flag_byte_o[3:0] == 4'h0 && !flag_byte_o[7] && !flag_byte_o[6])); // R10
endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W), .FLAG_N(FLAG_N)) u_chk (.*);

// File: tb/sim_alu8_flags.sv
`timescale 1ns/1ps
module sim_alu8_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_t = 4'd0;
  logic [7:0] a_t = 8'd0, b_t = 8'd0;
  logic       cy_t = 1'b0;
  logic [7:0] res_w, fb_w;
  logic [3:0] we_w;
  logic       rwe_w;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8_flags u0 (
    .clk(clk), .rst(rst), .op_i(op_t), .a_i(a_t), .b_i(b_t), .cy_i(cy_t),
    .res_o(res_w), .flag_byte_o(fb_w), .flag_we_o(we_w), .res_we_o(rwe_w)
  );

  // expected outputs from the requirement text
  task automatic model(input int op, input int a, input int b, input int c,
                       output logic [7:0] r, output logic [7:0] fb,
                       output logic [3:0] we, output logic rw);
    int s; bit z, n, h, cf;
    z = 0; n = 0; h = 0; cf = 0; we = 4'hF; rw = 1; r = a[7:0];
    case (op)
      0, 1, 15: begin
        if (op != 1) c = 0;
        s = a + b + c; r = s[7:0];
        h = ((a % 16) + (b % 16) + c) > 15; cf = s > 255;
        z = (op == 15) ? 0 : (r == 0);
      end
      2, 3, 4: begin
        if (op != 3) c = 0;
        s = a - b - c; if (op != 4) r = s[7:0];
        n = 1; h = ((a % 16) - (b % 16) - c) < 0; cf = s < 0;
        z = (s[7:0] == 0); rw = (op != 4);
      end
      5: begin s = a + 1; r = s[7:0]; z = (r == 0); h = (a % 16) == 15; we = 4'hE; end
      6: begin s = a - 1; r = s[7:0]; z = (r == 0); n = 1; h = (a % 16) == 0; we = 4'hE; end
      7: begin r = a[7:0] & b[7:0]; z = (r == 0); h = 1; end
      8: begin r = a[7:0] | b[7:0]; z = (r == 0); end
      9: begin r = a[7:0] ^ b[7:0]; z = (r == 0); end
      10: begin r = ~a[7:0]; n = 1; h = 1; we = 4'h6; end
      11: begin cf = a[7]; r = {a[6:0], a[7]}; end
      12: begin cf = a[0]; r = {a[0], a[7:1]}; end
      13: begin cf = a[7]; r = {a[6:0], c[0]}; end
      default: begin cf = a[0]; r = {c[0], a[7:1]}; end
    endcase
    fb = {z, n, h, cf, 4'h0};
  endtask

  // called on a falling edge; drives, waits one edge, checks
  task automatic apply_chk(input int op, input int a, input int b, input int c, input string tag);
    logic [7:0] er, efb; logic [3:0] ewe; logic erw;
    op_t = op[3:0]; a_t = a[7:0]; b_t = b[7:0]; cy_t = c[0];
    model(op, a, b, c, er, efb, ewe, erw);
    @(negedge clk);
    n_chk++;
    if (res_w !== er || fb_w !== efb || we_w !== ewe || rwe_w !== erw) begin
      n_err++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d: got res=%h fb=%h we=%h rwe=%b exp res=%h fb=%h we=%h rwe=%b",
               tag, op, a, b, c, res_w, fb_w, we_w, rwe_w, er, efb, ewe, erw);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; op_t = 4'd10; a_t = 8'h5A;
    repeat (2) @(negedge clk);
    n_chk++;
    if (res_w !== 8'h00 || fb_w !== 8'h00 || we_w !== 4'h0 || rwe_w !== 1'b0) begin
      n_err++;
      $display("FAIL R11 reset: got res=%h fb=%h we=%h rwe=%b exp all 0", res_w, fb_w, we_w, rwe_w);
    end
    rst = 1'b0;
  endtask

  task automatic t_latency;
    apply_chk(0, 8'h01, 8'h02, 0, "R11");
    op_t = 4'd0; a_t = 8'h10; b_t = 8'h10;
    #2;
    n_chk++;
    if (res_w !== 8'h03) begin
      n_err++; $display("FAIL R11 hold before edge: got %h exp 03", res_w);
    end
    @(negedge clk);
    n_chk++;
    if (res_w !== 8'h20) begin
      n_err++; $display("FAIL R11 update after edge: got %h exp 20", res_w);
    end
  endtask

  task automatic t_add;
    apply_chk(0, 8'h0F, 8'h01, 1, "R3");   // half-carry, carry-in ignored
    apply_chk(0, 8'hF0, 8'h11, 0, "R3");   // byte carry
    apply_chk(0, 8'h80, 8'h80, 0, "R3");   // zero with carry
    apply_chk(1, 8'hFF, 8'h00, 1, "R3");   // carry-in wraps
    apply_chk(1, 8'h07, 8'h08, 1, "R3");
  endtask

  task automatic t_sub;
    apply_chk(2, 8'h10, 8'h01, 1, "R4");   // half borrow
    apply_chk(2, 8'h00, 8'h01, 0, "R4");   // byte borrow
    apply_chk(2, 8'h42, 8'h42, 0, "R4");   // zero
    apply_chk(3, 8'h42, 8'h41, 1, "R4");   // borrow-in gives zero
    apply_chk(3, 8'h00, 8'h00, 1, "R4");
  endtask

  task automatic t_cp;
    apply_chk(4, 8'h3C, 8'h3C, 0, "R5");
    apply_chk(4, 8'h3C, 8'h40, 1, "R5");
  endtask

  task automatic t_incdec;
    apply_chk(5, 8'h0F, 8'h00, 1, "R6");
    apply_chk(5, 8'hFF, 8'h00, 0, "R6");
    apply_chk(6, 8'h10, 8'h00, 1, "R6");
    apply_chk(6, 8'h01, 8'h00, 0, "R6");
    apply_chk(6, 8'h00, 8'h00, 0, "R6");
  endtask

  task automatic t_logic;
    apply_chk(7, 8'hF0, 8'h0F, 1, "R7");
    apply_chk(8, 8'h00, 8'h00, 1, "R7");
    apply_chk(9, 8'hA5, 8'hA5, 1, "R7");
    apply_chk(9, 8'hA5, 8'h5A, 0, "R7");
  endtask

  task automatic t_rot;
    apply_chk(11, 8'h80, 8'h00, 0, "R8");
    apply_chk(12, 8'h01, 8'h00, 0, "R8");
    apply_chk(13, 8'h80, 8'h00, 0, "R8");  // result 0 yet zero flag low
    apply_chk(13, 8'h00, 8'h00, 1, "R8");
    apply_chk(14, 8'h01, 8'h00, 0, "R8");
    apply_chk(14, 8'h02, 8'h00, 1, "R8");
  endtask

  task automatic t_cpl;
    apply_chk(10, 8'h00, 8'h00, 1, "R9");
    apply_chk(10, 8'h3C, 8'hFF, 0, "R9");
  endtask

  task automatic t_spofs;
    apply_chk(15, 8'hF8, 8'h08, 1, "R10");  // result 0, zero flag low
    apply_chk(15, 8'h0F, 8'hFF, 0, "R10");  // negative offset
    apply_chk(15, 8'h20, 8'h01, 0, "R10");
  endtask

  task automatic t_sweep;
    int ops[8] = '{0, 1, 2, 3, 4, 7, 8, 9};
    for (int i = 0; i < 65536; i++) begin
      int a, b, k, op, c;
      string tg;
      a = i / 256; b = i % 256;
      k = (a ^ (b / 8) ^ (b * 3)) % 8;
      op = ops[k];
      c = ((a / 8) ^ (b / 64)) % 2;
      if (op <= 1) tg = "R3"; else if (op <= 3) tg = "R4";
      else if (op == 4) tg = "R5"; else tg = "R7";
      apply_chk(op, a, b, c, tg);
    end
  endtask

  task automatic t_opcodes;
    for (int op = 0; op < 16; op++) begin
      logic [7:0] er, efb; logic [3:0] ewe; logic erw;
      apply_chk(op, 8'h96, 8'h3B, 1, "R2");
      model(op, 8'h96, 8'h3B, 1, er, efb, ewe, erw);
      n_chk++;
      if (rwe_w !== (op != 4) || fb_w[3:0] !== 4'h0) begin
        n_err++;
        $display("FAIL R12/R1 op=%0d: got rwe=%b low=%h exp rwe=%b low=0", op, rwe_w, fb_w[3:0], (op != 4));
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_cp();
    t_incdec();
    t_logic();
    t_rot();
    t_cpl();
    t_spofs();
    t_opcodes();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R11 watchdog expired: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule